// File: doc/BRIEF.md
# Multi-mode floating-point rounding finalizer

This unit is the last step of a binary32 arithmetic datapath. It takes a result that has already been aligned, added and normalised, and produces the final packed word. The input result has a sign, a biased exponent, a 24-bit significand with its hidden bit, three guard/round/sticky bits and three condition flags: overflow, underflow and exact zero. A 3-bit mode input picks the rounding rule for each operation. The five usual directions are supported, along with two round-to-odd variants. The two odd variants differ only in the sign they give an exact zero whose sign the arithmetic left open.

The unit decides whether the significand is incremented. When the increment carries out of the significand, it renormalises. When the exponent runs out of range, it applies the overflow rule. The overflow, underflow and open-zero results depend on both the mode and the sign. One output register holds the packed word, so a result appears one clock after its inputs. Alignment, addition, normalisation, NaN handling and exception flags are done elsewhere.

Top module: `fpr_finalize`

## Requirements
- R1: Mode codes are 0 = nearest-even, 1 = toward zero, 2 = toward +inf, 3 = toward -inf, 4 = nearest-away, 5 = odd with positive open zero, 6 = odd with negative open zero. Code 7 behaves exactly as code 0.
- R2: Let inexact = g|r|s. Nearest-even increments when g and (r|s|significand bit 0) are set. Nearest-away increments whenever g is set. Toward zero never increments.
- R3: Toward +inf increments an inexact positive result and never a negative one. Toward -inf increments an inexact negative result and never a positive one.
- R4: Both odd modes increment only when the input is inexact and significand bit 0 is 0. An inexact input therefore always yields a packed word with bit 0 set.
- R5: When the increment carries out of the 24-bit significand, the fraction becomes the sum shifted right by one and the exponent grows by one. A subnormal (exponent field 0) that rounds up to 2^23 is packed with exponent field 1.
- R6: When a carry lifts the exponent to 255, the result follows the overflow rule of R7.
- R7: On overflow, modes 0, 4 and 7 give infinity (exponent 255, fraction 0). Mode 2 gives infinity for a positive result and mode 3 gives it for a negative one. Every other case gives the largest finite value (exponent 254, fraction all ones). Both results keep the input sign.
- R8: On underflow, modes 0, 1, 4 and 7 give zero. Mode 2 gives zero for a negative result and mode 3 gives it for a positive one. Every other case gives the smallest subnormal (exponent 0, fraction 1). Both results keep the input sign.
- R9: An exact zero whose sign is open (fixed-sign input low) is -0 under modes 3 and 6 and +0 under all other modes.
- R10: An exact zero with the fixed-sign input high is packed with the input sign in every mode.
- R11: Exact zero takes priority over overflow, and overflow takes priority over underflow.
- R12: While reset is held the output is 0. Otherwise the output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rmode | input | 3 | Rounding mode code (R1) |
| iz_sign | input | 1 | Sign of the intermediate result |
| iz_exp | input | 8 | Biased exponent; 0 means subnormal range |
| iz_mant | input | 24 | Significand including hidden bit (bit 23) |
| iz_grd | input | 1 | Guard bit |
| iz_rnd | input | 1 | Round bit |
| iz_stk | input | 1 | Sticky bit |
| iz_ovf | input | 1 | Magnitude beyond the finite range |
| iz_unf | input | 1 | Magnitude below the smallest subnormal |
| iz_zero | input | 1 | Result is exactly zero |
| iz_zfix | input | 1 | Sign of an exact zero is fixed by iz_sign |
| res | output | 32 | Packed binary32 result |

## Verification
The unit keeps no state other than the output word. A wrong mode decode or a wrong increment decision therefore shows in `res` on the clock edge after the offending inputs, and nothing is hidden to show up later. The bench sweeps every mode against both signs, all eight guard/round/sticky patterns and both significand parities. It also covers the carry, exponent-saturation, overflow, underflow and zero cases, then checks random vectors. Every expected word is computed from a separate rounding formulation that compares the remainder with the half-ulp point.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_ZERO      = 3'd1,
        RM_UP        = 3'd2,
        RM_DOWN      = 3'd3,
        RM_NEAR_AWAY = 3'd4,
        RM_ODD_POS   = 3'd5,
        RM_ODD_NEG   = 3'd6,
        RM_SPARE     = 3'd7
    } rmode_e;

    typedef enum logic [1:0] {
        INC_NEAR_EVEN = 2'd0,
        INC_NEAR_AWAY = 2'd1,
        INC_DIRECTED  = 2'd2,
        INC_ODD       = 2'd3
    } inc_kind_e;

    typedef struct packed {
        inc_kind_e kind;
        logic      dir_up;
        logic      ovf_inf;
        logic      unf_zero;
        logic      zero_neg;
    } rnd_policy_t;

endpackage

// File: rtl/fpr_mode_decode.sv
module fpr_mode_decode
    import fpr_pkg::*;
(
    input  logic [2:0]  rmode_i,
    input  logic        sign_i,
    output rnd_policy_t pol_o
);
    rmode_e mode;
    assign mode = rmode_e'(rmode_i);

    always_comb begin
        pol_o = '{kind: INC_NEAR_EVEN, dir_up: 1'b0, ovf_inf: 1'b1,
                  unf_zero: 1'b1, zero_neg: 1'b0};
        unique case (mode)
            RM_NEAR_EVEN, RM_SPARE: begin
                pol_o.kind = INC_NEAR_EVEN;
            end
            RM_ZERO: begin
                pol_o.kind    = INC_DIRECTED;
                pol_o.ovf_inf = 1'b0;
            end
            RM_UP: begin
                pol_o.kind     = INC_DIRECTED;
                pol_o.dir_up   = ~sign_i;
                pol_o.ovf_inf  = ~sign_i;
                pol_o.unf_zero = sign_i;
            end
            RM_DOWN: begin
                pol_o.kind     = INC_DIRECTED;
                pol_o.dir_up   = sign_i;
                pol_o.ovf_inf  = sign_i;
                pol_o.unf_zero = ~sign_i;
                pol_o.zero_neg = 1'b1;
            end
            RM_NEAR_AWAY: begin
                pol_o.kind = INC_NEAR_AWAY;
            end
            RM_ODD_POS: begin
                pol_o.kind     = INC_ODD;
                pol_o.ovf_inf  = 1'b0;
                pol_o.unf_zero = 1'b0;
            end
            RM_ODD_NEG: begin
                pol_o.kind     = INC_ODD;
                pol_o.ovf_inf  = 1'b0;
                pol_o.unf_zero = 1'b0;
                pol_o.zero_neg = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/fpr_round_incr.sv
module fpr_round_incr
    import fpr_pkg::*;
#(
    parameter int MAN_W = 23
) (
    input  inc_kind_e        kind_i,
    input  logic             dir_up_i,
    input  logic [MAN_W:0]   mant_i,
    input  logic             grd_i,
    input  logic             rnd_i,
    input  logic             stk_i,
    output logic [MAN_W+1:0] sum_o
);
    logic inexact;
    logic inc;

    assign inexact = grd_i | rnd_i | stk_i;

    always_comb begin
        unique case (kind_i)
            INC_NEAR_EVEN: inc = grd_i & (rnd_i | stk_i | mant_i[0]);
            INC_NEAR_AWAY: inc = grd_i;
            INC_DIRECTED:  inc = dir_up_i & inexact;
            INC_ODD:       inc = inexact & ~mant_i[0];
        endcase
    end

    assign sum_o = {1'b0, mant_i} + {{(MAN_W+1){1'b0}}, inc};
endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
    import fpr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   sign_i,
    input  logic [EXP_W-1:0]       exp_i,
    input  logic [MAN_W+1:0]       sum_i,
    input  logic                   ovf_i,
    input  logic                   unf_i,
    input  logic                   zero_i,
    input  logic                   zfix_i,
    input  rnd_policy_t            pol_i,
    output logic [EXP_W+MAN_W:0]   word_o
);
    localparam int                 WORD_W  = 1 + EXP_W + MAN_W;
    localparam logic [EXP_W:0]     EXP_TOP = {1'b0, {EXP_W{1'b1}}};
    localparam logic [EXP_W-1:0]   EXP_BIG = {{(EXP_W-1){1'b1}}, 1'b0};

    logic             carry;
    logic [EXP_W:0]   exp_ext;
    logic [MAN_W-1:0] frac;
    logic             sat;
    logic             zsign;

    assign carry = sum_i[MAN_W+1];
    assign exp_ext = (exp_i == '0) ? {{EXP_W{1'b0}}, sum_i[MAN_W]}
                                   : {1'b0, exp_i} + {{EXP_W{1'b0}}, carry};
    assign frac  = carry ? sum_i[MAN_W:1] : sum_i[MAN_W-1:0];
    assign sat   = exp_ext >= EXP_TOP;
    assign zsign = zfix_i ? sign_i : pol_i.zero_neg;

    always_comb begin
        if (zero_i)
            word_o = {zsign, {(WORD_W-1){1'b0}}};
        else if (ovf_i || sat)
            word_o = pol_i.ovf_inf ? {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}}
                                   : {sign_i, EXP_BIG, {MAN_W{1'b1}}};
        else if (unf_i)
            word_o = pol_i.unf_zero ? {sign_i, {(WORD_W-1){1'b0}}}
                                    : {sign_i, {(WORD_W-2){1'b0}}, 1'b1};
        else
            word_o = {sign_i, exp_ext[EXP_W-1:0], frac};
    end
endmodule

// File: rtl/fpr_finalize.sv
module fpr_finalize
    import fpr_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           rmode,
    input  logic                 iz_sign,
    input  logic [EXP_W-1:0]     iz_exp,
    input  logic [MAN_W:0]       iz_mant,
    input  logic                 iz_grd,
    input  logic                 iz_rnd,
    input  logic                 iz_stk,
    input  logic                 iz_ovf,
    input  logic                 iz_unf,
    input  logic                 iz_zero,
    input  logic                 iz_zfix,
    output logic [EXP_W+MAN_W:0] res
);
    localparam int WORD_W = 1 + EXP_W + MAN_W;

    rnd_policy_t      pol;
    logic [MAN_W+1:0] sum;
    logic [WORD_W-1:0] word_d;

    fpr_mode_decode u_dec (
        .rmode_i (rmode),
        .sign_i  (iz_sign),
        .pol_o   (pol)
    );

    fpr_round_incr #(.MAN_W(MAN_W)) u_inc (
        .kind_i   (pol.kind),
        .dir_up_i (pol.dir_up),
        .mant_i   (iz_mant),
        .grd_i    (iz_grd),
        .rnd_i    (iz_rnd),
        .stk_i    (iz_stk),
        .sum_o    (sum)
    );

    fpr_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
        .sign_i (iz_sign),
        .exp_i  (iz_exp),
        .sum_i  (sum),
        .ovf_i  (iz_ovf),
        .unf_i  (iz_unf),
        .zero_i (iz_zero),
        .zfix_i (iz_zfix),
        .pol_i  (pol),
        .word_o (word_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res <= '0;
        else        res <= word_d;
    end

    logic plain;
    assign plain = !iz_zero && !iz_ovf && !iz_unf;

    a_r7_ovf_zero_mode_maxfin: assert property (@(posedge clk) disable iff (!rst_n)
        (iz_ovf && !iz_zero && rmode == 3'd1) |=>
        res[WORD_W-2:0] == {{(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}});

    a_r9_down_open_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (iz_zero && !iz_zfix && rmode == 3'd3) |=> res == {1'b1, {(WORD_W-1){1'b0}}});

    a_r10_fixed_zero_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (iz_zero && iz_zfix) |=> res == {$past(iz_sign), {(WORD_W-1){1'b0}}});

    a_r4_odd_inexact_lsb_set: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && (rmode == 3'd5 || rmode == 3'd6) && (iz_grd || iz_rnd || iz_stk)) |=> res[0]);

    a_r8_unf_odd_min_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
        (iz_unf && !iz_ovf && !iz_zero && rmode == 3'd5) |=>
        res[WORD_W-2:0] == {{(WORD_W-2){1'b0}}, 1'b1});

    a_r2_zero_mode_truncates: assert property (@(posedge clk) disable iff (!rst_n)
        (plain && rmode == 3'd1 && iz_exp != '0) |=>
        res[WORD_W-2:0] == {$past(iz_exp), $past(iz_mant[MAN_W-1:0])});
endmodule

// File: tb/tb_fpr_finalize.sv
module tb_fpr_finalize;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rmode = '0;
    logic        iz_sign = 1'b0;
    logic [7:0]  iz_exp = '0;
    logic [23:0] iz_mant = '0;
    logic        iz_grd = 1'b0, iz_rnd = 1'b0, iz_stk = 1'b0;
    logic        iz_ovf = 1'b0, iz_unf = 1'b0, iz_zero = 1'b0, iz_zfix = 1'b0;
    logic [31:0] res;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fpr_finalize dut (
        .clk(clk), .rst_n(rst_n), .rmode(rmode), .iz_sign(iz_sign),
        .iz_exp(iz_exp), .iz_mant(iz_mant), .iz_grd(iz_grd), .iz_rnd(iz_rnd),
        .iz_stk(iz_stk), .iz_ovf(iz_ovf), .iz_unf(iz_unf), .iz_zero(iz_zero),
        .iz_zfix(iz_zfix), .res(res)
    );

    function automatic logic [31:0] ovf_word(input int md, input logic s);
        logic inf;
        inf = (md == 0 || md == 4 || md == 7) || (md == 2 && !s) || (md == 3 && s);
        return inf ? {s, 8'hFF, 23'h0} : {s, 8'hFE, 23'h7FFFFF};
    endfunction

    function automatic logic [31:0] unf_word(input int md, input logic s);
        logic z;
        z = (md == 0 || md == 1 || md == 4 || md == 7) || (md == 2 && s) || (md == 3 && !s);
        return z ? {s, 31'h0} : {s, 31'h1};
    endfunction

    function automatic logic [31:0] ref_word(input int md, input logic s, input logic [7:0] e,
            input logic [23:0] m, input logic g, input logic r, input logic st,
            input logic ov, input logic un, input logic zr, input logic zf);
        int rem;
        logic up;
        int mm;
        int ee;
        if (zr) return {(zf ? s : (md == 3 || md == 6)), 31'h0};
        if (ov) return ovf_word(md, s);
        if (un) return unf_word(md, s);
        rem = 4*g + 2*r + st;
        case (md)
            1: up = 1'b0;
            2: up = (rem != 0) && !s;
            3: up = (rem != 0) && s;
            4: up = rem >= 4;
            5, 6: up = (rem != 0) && !m[0];
            default: up = (rem > 4) || (rem == 4 && m[0]);
        endcase
        mm = int'(m) + (up ? 1 : 0);
        ee = int'(e);
        if (mm >= (1 << 24)) begin mm = mm / 2; ee = ee + 1; end
        if (e == 0 && mm >= (1 << 23)) ee = 1;
        if (ee >= 255) return ovf_word(md, s);
        return {s, 8'(ee), 23'(mm)};
    endfunction

    task automatic apply(input int md, input logic s, input logic [7:0] e, input logic [23:0] m,
            input logic g, input logic r, input logic st, input logic ov, input logic un,
            input logic zr, input logic zf, input string tag);
        logic [31:0] exp_w;
        @(negedge clk);
        rmode = 3'(md); iz_sign = s; iz_exp = e; iz_mant = m;
        iz_grd = g; iz_rnd = r; iz_stk = st; iz_ovf = ov; iz_unf = un;
        iz_zero = zr; iz_zfix = zf;
        exp_w = ref_word(md, s, e, m, g, r, st, ov, un, zr, zf);
        @(negedge clk);
        n_chk++;
        if (res !== exp_w) begin
            n_bad++;
            $display("FAIL %s mode=%0d actual=%08h expected=%08h", tag, md, res, exp_w);
        end
    endtask

    function automatic string mode_tag(input int md);
        case (md)
            1, 0: return "R2";
            2, 3: return "R3";
            4: return "R2";
            5, 6: return "R4";
            default: return "R1";
        endcase
    endfunction

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (res !== 32'h0) begin
            n_bad++;
            $display("FAIL R12 reset actual=%08h expected=00000000", res);
        end
        rst_n = 1'b1;

        // increment rules: every mode, sign, g/r/s pattern and parity
        for (int md = 0; md < 8; md++)
            for (int s = 0; s < 2; s++)
                for (int grs = 0; grs < 8; grs++)
                    for (int lsb = 0; lsb < 2; lsb++)
                        apply(md, s[0], 8'd100, 24'h800000 | 24'(lsb), grs[2], grs[1], grs[0],
                              0, 0, 0, 0, mode_tag(md));

        // R5 carry out of significand, subnormal promotion
        for (int md = 0; md < 8; md++)
            for (int s = 0; s < 2; s++) begin
                apply(md, s[0], 8'd100, 24'hFFFFFF, 1, 1, 1, 0, 0, 0, 0, "R5");
                apply(md, s[0], 8'd0, 24'h7FFFFF, 1, 0, 1, 0, 0, 0, 0, "R5");
                apply(md, s[0], 8'd0, 24'h000010, 0, 1, 0, 0, 0, 0, 0, "R5");
                // R6 carry into exponent 255
                apply(md, s[0], 8'd254, 24'hFFFFFF, 1, 1, 0, 0, 0, 0, 0, "R6");
            end

        // R7 overflow, R8 underflow, R9/R10 zeros, R11 priority
        for (int md = 0; md < 8; md++)
            for (int s = 0; s < 2; s++) begin
                apply(md, s[0], 8'd200, 24'hC00000, 0, 0, 0, 1, 0, 0, 0, "R7");
                apply(md, s[0], 8'd0, 24'h000000, 0, 1, 1, 0, 1, 0, 0, "R8");
                apply(md, s[0], 8'd0, 24'h000000, 0, 0, 0, 0, 0, 1, 0, "R9");
                apply(md, s[0], 8'd0, 24'h000000, 0, 0, 0, 0, 0, 1, 1, "R10");
                apply(md, s[0], 8'd50, 24'h900000, 1, 0, 0, 1, 1, 1, 0, "R11");
                apply(md, s[0], 8'd50, 24'h900000, 1, 0, 0, 1, 1, 0, 0, "R11");
            end

        // random vectors
        for (int k = 0; k < 3000; k++) begin
            int md;
            logic [7:0] e;
            logic [23:0] m;
            logic [31:0] rv;
            rv = $urandom;
            md = int'(rv[2:0]);
            e = 8'($urandom_range(0, 254));
            m = 24'($urandom);
            m[23] = (e != 0);
            apply(md, rv[3], e, m, rv[4], rv[5], rv[6], rv[7] & rv[8] & rv[9],
                  rv[10] & rv[11] & rv[12], rv[13] & rv[14] & rv[15], rv[16],
                  mode_tag(md));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule